// File: doc/BRIEF.md
# Interrupt Pin Service Engine

This block watches a set of raw interrupt lines and turns them into delivery requests for a processor-side interrupt controller. Each line has a routing entry, written through a narrow configuration port. The entry holds a vector, a destination, a destination mode, a delivery mode, a trigger mode, an input polarity and a mask. The engine keeps a pending bit that follows each line's effective level. It queues one request per line. It issues the queued requests one at a time over a valid/ready handshake, lowest line number first.

Level-triggered lines carry a remote-pending bit. The bit is set when a delivery for that line is accepted. It blocks further deliveries from that line until an end-of-interrupt carrying the same vector comes back. An end-of-interrupt is checked first against a bitmap of vectors in use, rebuilt from the table. It then sweeps the table one entry per cycle. Every rising effective level yields a one-cycle status pulse on that line's bit: delivered or coalesced. Line 0 is always sent in physical mode to destination 0.

Top module: `irq_pin_engine`

## Requirements
- R1: The effective level of a line is its raw input XOR the entry's polarity bit (bit 12 of `cfg_data`, 1 = active low). Changing the polarity alone can therefore produce a rising effective level.
- R2: An unmasked edge-triggered line (bit 13 = 0) produces one delivery for each rise of its effective level, and none while the level stays high. A rise while that line's request is still queued is reported as coalesced and adds no delivery.
- R3: An accepted delivery from a level-triggered line (bit 13 = 1) sets its remote-pending bit. Later rises of that line are reported as coalesced and produce no delivery.
- R4: A masked line (bit 14 = 1) produces no delivery and raises neither status pulse.
- R5: An end-of-interrupt whose vector equals a level-triggered entry's vector clears that line's remote-pending bit. The line is delivered again if it is unmasked and its effective level is still high; it is not delivered if the level is low.
- R6: An end-of-interrupt whose vector is in no entry leaves all state unchanged, and `eoi_done` pulses on the cycle after acceptance. An accepted in-use vector holds `eoi_ready` low for exactly NPINS cycles and then pulses `eoi_done`.
- R7: A delivery from line 0 always carries destination mode 0 (physical) and destination 0, whatever its entry holds.
- R8: Writing an unmasked level-triggered entry whose line is currently active delivers that line without any new edge, and clears its remote-pending bit.
- R9: Requests pending together are issued in ascending line order, one per accepted handshake. While `dlv_valid` is high and `dlv_ready` is low, the request stays unchanged.
- R10: `evt_delivered` and `evt_coalesced` are one-cycle pulses on the line's bit and are never both set for the same line.
- R11: A delivery carries the entry's vector (bits 7:0), delivery mode (bits 10:8), destination mode (bit 11, 1 = logical), trigger mode and destination (bits 22:15). After reset every entry is masked, `dlv_valid` is 0 and `eoi_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Raw interrupt line levels |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_data | input | 23 | Routing entry contents |
| eoi_valid | input | 1 | End-of-interrupt offered |
| eoi_vector | input | 8 | Vector being retired |
| eoi_ready | output | 1 | Engine idle, end-of-interrupt accepted |
| eoi_done | output | 1 | Pulse when an end-of-interrupt is finished |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Receiver takes the request |
| dlv_pin | output | IDX_W | Line the request comes from |
| dlv_vector | output | 8 | Vector |
| dlv_dest | output | 8 | Destination |
| dlv_dest_mode | output | 1 | 1 = logical, 0 = physical |
| dlv_mode | output | 3 | Delivery mode |
| dlv_level | output | 1 | 1 = level-triggered |
| evt_delivered | output | NPINS | Per-line pulse: rise queued for delivery |
| evt_coalesced | output | NPINS | Per-line pulse: rise merged into earlier one |

## Verification
The assertions take for granted that the receiver never retracts `dlv_ready` mid-handshake in a way that matters. They also assume `eoi_valid` is offered only as a request and is dropped once taken, so a held request is checked only while `eoi_ready` is low. The stimulus drives every input at the falling edge. It offers end-of-interrupts only while `eoi_ready` is high and writes only indices below NPINS. Line levels change only once the engine has settled, so each status pulse can be tied to one stimulus step.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              masked;
    logic              level;
    logic              act_low;
    logic              logical;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } route_t;

  localparam int ROUTE_W = $bits(route_t);
  localparam int NVEC    = 1 << VEC_W;

  localparam route_t ROUTE_RST = '{dest: '0, masked: 1'b1, level: 1'b0,
                                   act_low: 1'b0, logical: 1'b0,
                                   mode: '0, vector: '0};
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] pol,
  output logic [N-1:0] eff
);
  logic [N-1:0] s_q;

  always_ff @(posedge clk) begin
    if (rst) s_q <= '0;
    else     s_q <= raw;
  end

  assign eff = s_q ^ pol;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter  int N     = 24,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_eoi_scan.sv
module irq_eoi_scan
  import irq_svc_pkg::*;
#(
  parameter  int N     = 24,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic [NVEC-1:0]  used,
  output logic             eoi_ready,
  output logic             eoi_done,
  output logic             scan_en,
  output logic [IDX_W-1:0] scan_idx,
  output logic [VEC_W-1:0] scan_vec
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      eoi_done <= 1'b0;
      scan_idx <= '0;
      scan_vec <= '0;
    end else begin
      eoi_done <= 1'b0;
      if (!busy_q && eoi_valid) begin
        scan_vec <= eoi_vector;
        scan_idx <= '0;
        if (used[eoi_vector]) busy_q   <= 1'b1;
        else                  eoi_done <= 1'b1;
      end else if (busy_q) begin
        if (scan_idx == IDX_W'(N - 1)) begin
          busy_q   <= 1'b0;
          eoi_done <= 1'b1;
        end else begin
          scan_idx <= scan_idx + 1'b1;
        end
      end
    end
  end

  assign eoi_ready = !busy_q;
  assign scan_en   = busy_q;
endmodule

// File: rtl/irq_pin_engine.sv
module irq_pin_engine
  import irq_svc_pkg::*;
#(
  parameter  int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ROUTE_W-1:0] cfg_data,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  output logic              eoi_ready,
  output logic              eoi_done,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [IDX_W-1:0]  dlv_pin,
  output logic [VEC_W-1:0]  dlv_vector,
  output logic [DEST_W-1:0] dlv_dest,
  output logic              dlv_dest_mode,
  output logic [MODE_W-1:0] dlv_mode,
  output logic              dlv_level,
  output logic [NPINS-1:0]  evt_delivered,
  output logic [NPINS-1:0]  evt_coalesced
);
  route_t tbl [NPINS];
  route_t wr_r;
  route_t pick_r;

  logic [NPINS-1:0] eff, pol_v, irr_q, remote_q, req_q;
  logic [NPINS-1:0] rise, set_evt, coal, clr_wr, set_wr, clr_eoi, set_eoi, acc_oh;
  logic [NPINS-1:0] req_d, remote_d;
  logic [NVEC-1:0]  used_q, used_d;
  logic             scan_en;
  logic [IDX_W-1:0] scan_idx;
  logic [VEC_W-1:0] scan_vec;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             acc;

  assign wr_r = route_t'(cfg_data);
  assign acc  = dlv_valid && dlv_ready;

  irq_in_sync #(.N(NPINS)) u_sync (
    .clk(clk), .rst(rst), .raw(pin_in), .pol(pol_v), .eff(eff)
  );

  irq_eoi_scan #(.N(NPINS)) u_eoi (
    .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .used(used_q), .eoi_ready(eoi_ready), .eoi_done(eoi_done),
    .scan_en(scan_en), .scan_idx(scan_idx), .scan_vec(scan_vec)
  );

  irq_lowest_pick #(.N(NPINS)) u_pick (
    .req(req_q & ~acc_oh), .found(pick_found), .idx(pick_idx)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign pol_v[g] = tbl[g].act_low;

    always_comb begin
      rise[g]    = eff[g] && !irr_q[g];
      set_evt[g] = rise[g] && !tbl[g].masked && !req_q[g] &&
                   !(tbl[g].level && remote_q[g]);
      coal[g]    = rise[g] && !tbl[g].masked && !set_evt[g];
      clr_wr[g]  = cfg_we && (cfg_idx == IDX_W'(g));
      set_wr[g]  = clr_wr[g] && wr_r.level && !wr_r.masked && irr_q[g];
      clr_eoi[g] = scan_en && (scan_idx == IDX_W'(g)) && tbl[g].level &&
                   (tbl[g].vector == scan_vec);
      set_eoi[g] = clr_eoi[g] && !tbl[g].masked && irr_q[g];
      acc_oh[g]  = acc && (dlv_pin == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
      if (rst)            tbl[g] <= ROUTE_RST;
      else if (clr_wr[g]) tbl[g] <= wr_r;
    end
  end

  always_comb begin
    used_d = '0;
    for (int i = 0; i < NPINS; i++) used_d[tbl[i].vector] = 1'b1;
  end

  assign remote_d = (remote_q & ~clr_wr & ~clr_eoi) | (acc_oh & {NPINS{dlv_level}});
  assign req_d    = (req_q & ~acc_oh) | set_evt | set_wr | set_eoi;
  assign pick_r   = tbl[pick_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q        <= '0;
      irr_q         <= '0;
      remote_q      <= '0;
      req_q         <= '0;
      evt_delivered <= '0;
      evt_coalesced <= '0;
      dlv_valid     <= 1'b0;
      dlv_pin       <= '0;
      dlv_vector    <= '0;
      dlv_dest      <= '0;
      dlv_dest_mode <= 1'b0;
      dlv_mode      <= '0;
      dlv_level     <= 1'b0;
    end else begin
      used_q        <= used_d;
      irr_q         <= eff;
      remote_q      <= remote_d;
      req_q         <= req_d;
      evt_delivered <= set_evt;
      evt_coalesced <= coal;
      if (!dlv_valid || acc) begin
        dlv_valid <= pick_found;
        if (pick_found) begin
          dlv_pin       <= pick_idx;
          dlv_vector    <= pick_r.vector;
          dlv_mode      <= pick_r.mode;
          dlv_level     <= pick_r.level;
          dlv_dest      <= (pick_idx == '0) ? '0 : pick_r.dest;
          dlv_dest_mode <= (pick_idx == '0) ? 1'b0 : pick_r.logical;
        end
      end
    end
  end
endmodule

// File: rtl/irq_pin_engine_chk.sv
module irq_pin_engine_chk #(
  parameter  int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst,
  input logic             eoi_ready,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [IDX_W-1:0] dlv_pin,
  input logic [7:0]       dlv_vector,
  input logic [7:0]       dlv_dest,
  input logic             dlv_dest_mode,
  input logic [NPINS-1:0] evt_delivered,
  input logic [NPINS-1:0] evt_coalesced
);
  logic [IDX_W+1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)             busy_cnt <= '0;
    else if (!eoi_ready) busy_cnt <= busy_cnt + 1'b1;
    else                 busy_cnt <= '0;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_pin) && $stable(dlv_vector))); // R9

  AST_PIN0_PHYS: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_pin == '0) |-> (!dlv_dest_mode && dlv_dest == '0)); // R7

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    (evt_delivered & evt_coalesced) == '0); // R10

  AST_EOI_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= (IDX_W + 2)'(NPINS)); // R6
endmodule

bind irq_pin_engine irq_pin_engine_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .eoi_ready(eoi_ready), .dlv_valid(dlv_valid),
  .dlv_ready(dlv_ready), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
  .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode),
  .evt_delivered(evt_delivered), .evt_coalesced(evt_coalesced)
);

// File: tb/test_irq_pin_engine.sv
`timescale 1ns/1ps
module test_irq_pin_engine;
  localparam int NPINS = 24;
  localparam int IDX_W = $clog2(NPINS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPINS-1:0] pin_in = '0;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [22:0] cfg_data = '0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic eoi_ready, eoi_done, dlv_valid;
  logic dlv_ready = 1'b0;
  logic [IDX_W-1:0] dlv_pin;
  logic [7:0] dlv_vector, dlv_dest;
  logic dlv_dest_mode, dlv_level;
  logic [2:0] dlv_mode;
  logic [NPINS-1:0] evt_delivered, evt_coalesced;

  int total = 0;
  int bad = 0;
  logic [NPINS-1:0] acc_d = '0;
  logic [NPINS-1:0] acc_c = '0;

  always #2 clk = ~clk;

  irq_pin_engine #(.NPINS(NPINS)) i_irq_pin_engine (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_ready(eoi_ready), .eoi_done(eoi_done), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
    .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode),
    .dlv_level(dlv_level), .evt_delivered(evt_delivered),
    .evt_coalesced(evt_coalesced)
  );

  always @(negedge clk) begin
    acc_d = acc_d | evt_delivered;
    acc_c = acc_c | evt_coalesced;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_evt();
    @(negedge clk);
    acc_d = '0;
    acc_c = '0;
  endtask

  task automatic cfg(input int pin, input logic [7:0] vec, input logic [2:0] mode,
                     input logic lg, input logic alow, input logic lvl,
                     input logic msk, input logic [7:0] dst);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_idx  = IDX_W'(pin);
    cfg_data = {dst, msk, lvl, alow, lg, mode, vec};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_dlv(input string tag, input int pin, input logic [7:0] vec,
                            input logic [7:0] dst, input logic lg,
                            input logic [2:0] mode, input logic lvl);
    int k = 0;
    while (!dlv_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " valid"}, dlv_valid, 1);
    chk({tag, " pin"}, dlv_pin, pin);
    chk({tag, " vector"}, dlv_vector, vec);
    chk({tag, " dest"}, dlv_dest, dst);
    chk({tag, " dest_mode"}, dlv_dest_mode, lg);
    chk({tag, " mode"}, dlv_mode, mode);
    chk({tag, " trigger"}, dlv_level, lvl);
    dlv_ready = 1'b1;
    @(negedge clk);
    dlv_ready = 1'b0;
  endtask

  task automatic expect_none(input string tag, input int n);
    logic seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (dlv_valid) seen = 1'b1;
    end
    chk(tag, seen, 0);
  endtask

  task automatic send_eoi(input string tag, input logic [7:0] vec, input int exp_busy);
    int busy = 0;
    logic seen = 1'b0;
    @(negedge clk);
    while (!eoi_ready) @(negedge clk);
    eoi_valid  = 1'b1;
    eoi_vector = vec;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(negedge clk);
      if (k == 0) eoi_valid = 1'b0;
      if (!eoi_ready) busy++;
      if (eoi_done) seen = 1'b1;
    end
    chk({tag, " done"}, seen, 1);
    chk({tag, " busy cycles"}, busy, exp_busy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 reset dlv_valid", dlv_valid, 0);
    chk("R11 reset eoi_ready", eoi_ready, 1);
    chk("R11 reset events", {evt_delivered, evt_coalesced}, 0);
    clr_evt();
    pin_in[6] = 1'b1;
    expect_none("R11 masked after reset", 10);
    chk("R11 no event when masked", {acc_d, acc_c}, 0);
    pin_in[6] = 1'b0;
    repeat (4) @(negedge clk);

    // R2 R7 R10 R11: sweep every line as unmasked edge-triggered
    for (int i = 0; i < NPINS; i++) begin
      logic [7:0] v, d;
      v = 8'h20 + 8'(i);
      d = 8'h40 + 8'(i);
      cfg(i, v, 3'(i % 8), 1'(i % 2), 1'b0, 1'b0, 1'b0, d);
      clr_evt();
      pin_in[i] = 1'b1;
      if (i == 0) expect_dlv("R7 line0 forced", 0, v, 8'h00, 1'b0, 3'(i % 8), 1'b0);
      else        expect_dlv("R11 sweep fields", i, v, d, 1'(i % 2), 3'(i % 8), 1'b0);
      chk("R10 delivered pulse", acc_d, 1 << i);
      chk("R10 no coalesced pulse", acc_c, 0);
      expect_none("R2 no repeat while high", 8);
      pin_in[i] = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R1: polarity flip with line low raises effective level
    clr_evt();
    cfg(5, 8'h25, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 8'h45);
    expect_dlv("R1 polarity flip", 5, 8'h25, 8'h45, 1'b1, 3'd5, 1'b0);
    pin_in[5] = 1'b1;
    expect_none("R1 active-low line driven high", 8);
    pin_in[5] = 1'b0;
    expect_dlv("R1 active-low line driven low", 5, 8'h25, 8'h45, 1'b1, 3'd5, 1'b0);

    // R4: masked edge line
    cfg(8, 8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    clr_evt();
    pin_in[8] = 1'b1;
    expect_none("R4 masked line", 10);
    chk("R4 masked no status", {acc_d, acc_c}, 0);
    pin_in[8] = 1'b0;

    // R3 R5 R6: level line with remote-pending
    cfg(3, 8'h63, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07);
    pin_in[3] = 1'b1;
    expect_dlv("R3 level first", 3, 8'h63, 8'h07, 1'b0, 3'd1, 1'b1);
    pin_in[3] = 1'b0;
    repeat (3) @(negedge clk);
    clr_evt();
    pin_in[3] = 1'b1;
    expect_none("R3 blocked by remote", 12);
    chk("R3 coalesced pulse", acc_c, 1 << 3);
    chk("R3 no delivered pulse", acc_d, 0);
    send_eoi("R5 eoi match", 8'h63, NPINS);
    expect_dlv("R5 redelivered", 3, 8'h63, 8'h07, 1'b0, 3'd1, 1'b1);
    send_eoi("R6 unused vector", 8'hA5, 0);
    pin_in[3] = 1'b0;
    repeat (3) @(negedge clk);
    clr_evt();
    pin_in[3] = 1'b1;
    expect_none("R6 remote kept", 10);
    chk("R6 still coalesced", acc_c, 1 << 3);
    pin_in[3] = 1'b0;
    repeat (3) @(negedge clk);
    send_eoi("R5 eoi line low", 8'h63, NPINS);
    expect_none("R5 no redeliver when low", 10);
    clr_evt();
    pin_in[3] = 1'b1;
    expect_dlv("R5 remote cleared", 3, 8'h63, 8'h07, 1'b0, 3'd1, 1'b1);
    chk("R5 delivered pulse", acc_d, 1 << 3);

    // R8: unmask while line active
    cfg(9, 8'h70, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'h09);
    pin_in[9] = 1'b1;
    expect_none("R8 masked level", 8);
    cfg(9, 8'h70, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h09);
    expect_dlv("R8 service on write", 9, 8'h70, 8'h09, 1'b1, 3'd2, 1'b1);
    pin_in[9] = 1'b0;
    repeat (3) @(negedge clk);

    // R9: ascending order and hold under back-pressure
    @(negedge clk);
    pin_in[20] = 1'b1;
    pin_in[12] = 1'b1;
    pin_in[4]  = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 held valid", dlv_valid, 1);
    chk("R9 lowest first", dlv_pin, 4);
    repeat (3) @(negedge clk);
    chk("R9 stable pin", dlv_pin, 4);
    expect_dlv("R9 order 1", 4, 8'h24, 8'h44, 1'b0, 3'd4, 1'b0);
    expect_dlv("R9 order 2", 12, 8'h2C, 8'h4C, 1'b0, 3'd4, 1'b0);
    expect_dlv("R9 order 3", 20, 8'h34, 8'h54, 1'b0, 3'd4, 1'b0);
    expect_none("R9 nothing extra", 8);
    pin_in[4] = 1'b0; pin_in[12] = 1'b0; pin_in[20] = 1'b0;
    repeat (3) @(negedge clk);

    // R2: edge rise while request queued is coalesced
    clr_evt();
    pin_in[15] = 1'b1;
    repeat (6) @(negedge clk);
    pin_in[15] = 1'b0;
    repeat (3) @(negedge clk);
    pin_in[15] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 queued rise coalesced", acc_c, 1 << 15);
    chk("R2 first rise delivered", acc_d, 1 << 15);
    expect_dlv("R2 single delivery", 15, 8'h2F, 8'h4F, 1'b1, 3'd7, 1'b0);
    expect_none("R2 no second delivery", 12);
    pin_in[15] = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule